// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a timer peripheral with a counter and a set of compare registers, all reached over a single-cycle register bus. The counter advances on ticks from a selectable source, and a programmable prescaler divides that source down. The counter is free-running by default. When free-run is off, it instead restarts at zero after reaching the first compare value.

Three compare registers each raise a sticky flag in the status register when the counter steps onto their value. Software clears a flag by writing a one to it. An interrupt line is high while any enabled flag is pending.

A self-clearing software reset returns the block to its idle state. It keeps the source selection and the counting-mode bits. Everything runs in one clock domain, and the slower tick sources arrive as single-cycle enable pulses.

Top module: `cmp_timer`

## Requirements
- R1: After rst_n the registers read 0 and irq is 0. The word addresses on bus_addr are: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, and 7 counter. The counter register is read-only. A write takes effect at the clock edge where bus_wr is high, and bus_rdata shows the addressed register combinationally.
- R2: The control field sel (bits 3:1) chooses the tick source. The codes are: 0 none, 1 every clock, 2 tick_hf, 3 tick_ext, 4 tick_slow, 5 tick_fix, and 6/7 none. Source 5 counts only while bit 5 (fixed-source enable) is 1. Pulses on an unselected source do not move the counter.
- R3: A prescaler value P makes the counter advance once per P+1 selected ticks, so P=0 advances on every tick.
- R4: The counter advances only while control bit 0 (enable) is 1. Writing the control register to 0 stops the counter, which then holds its value.
- R5: With control bit 4 (free-run) at 1, the counter counts through compare matches. With it at 0, an advance from a value equal to compare 1 goes to 0.
- R6: The counter wraps from all ones to 0.
- R7: Status bit k-1 (k=1..3) is set when the counter advances to a value equal to compare k.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: A match in the same cycle as a clear of that flag leaves the flag set.
- R10: irq is 1 exactly while some status bit and the same bit of the interrupt-enable register are both 1.
- R11: Writing control with bit 15 at 1 starts a software reset. Bit 15 reads 1 for the 4 cycles after that write, then reads 0. Bus writes are ignored while the reset is running.
- R12: The software reset clears the prescaler, status, enable, compare and counter registers, and clears control bit 0. It keeps control bits 3:1, 4 and 5 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| tick_hf | input | 1 | High-rate tick enable |
| tick_ext | input | 1 | External tick enable |
| tick_slow | input | 1 | Slow (32 kHz class) tick enable |
| tick_fix | input | 1 | Fixed 24 MHz class tick enable |
| irq | output | 1 | Interrupt request |

## Verification
Every tick source is tested alone with counted pulses, and pulses are also sent on the wrong source. This tells apart a selector that decodes each code from one that counts every tick.

The same ext pulse trains run with the prescaler at 0 and at 2, with free-run on and off across the first compare value, and across the counter's all-ones value. These runs separate division, restart and wrap behaviour.

Flag handling is tested in several ways:
- status writes of 0 bits;
- status writes of 1 bits;
- a clear issued in the very cycle a match occurs, which shows whether the match is given priority.

The software reset is read on consecutive cycles to measure its exact length, and then each register is read back to see which fields survived.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_PRE   = 3'd1,
    A_STAT  = 3'd2,
    A_IEN   = 3'd3,
    A_CMP1  = 3'd4,
    A_CMP2  = 3'd5,
    A_CMP3  = 3'd6,
    A_COUNT = 3'd7
  } reg_addr_e;

  localparam logic [2:0] SRC_OFF  = 3'd0;
  localparam logic [2:0] SRC_BUS  = 3'd1;
  localparam logic [2:0] SRC_HF   = 3'd2;
  localparam logic [2:0] SRC_EXT  = 3'd3;
  localparam logic [2:0] SRC_SLOW = 3'd4;
  localparam logic [2:0] SRC_FIX  = 3'd5;

  localparam int CB_SWR = 15;

  typedef struct packed {
    logic       fix_en;
    logic       free;
    logic [2:0] sel;
    logic       en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.en     = w[0];
    c.sel    = w[3:1];
    c.free   = w[4];
    c.fix_en = w[5];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c, input logic busy);
    logic [31:0] w;
    w         = '0;
    w[0]      = c.en;
    w[3:1]    = c.sel;
    w[4]      = c.free;
    w[5]      = c.fix_en;
    w[CB_SWR] = busy;
    return w;
  endfunction

  // Next counter value: restart after the first compare unless free-running.
  function automatic logic [31:0] cnt_step(input logic [31:0] cur, input logic [31:0] lim,
                                           input logic free, input logic [31:0] all1);
    if (!free && cur == lim) return '0;
    return (cur + 32'd1) & all1;
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen import tmr_pkg::*; #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [2:0]       sel,
  input  logic             fix_en,
  input  logic             tick_hf,
  input  logic             tick_ext,
  input  logic             tick_slow,
  input  logic             tick_fix,
  input  logic [PRE_W-1:0] pre,
  output logic             adv
);

  logic             src;
  logic [PRE_W-1:0] pcnt;
  logic             hit;

  always_comb begin
    case (sel)
      SRC_BUS:  src = 1'b1;
      SRC_HF:   src = tick_hf;
      SRC_EXT:  src = tick_ext;
      SRC_SLOW: src = tick_slow;
      SRC_FIX:  src = tick_fix & fix_en;
      default:  src = 1'b0;
    endcase
  end

  assign hit = (pcnt >= pre);
  assign adv = run && src && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (clr || !run)    pcnt <= '0;
    else if (src)            pcnt <= hit ? '0 : pcnt + 1'b1;
  end

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core import tmr_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       adv,
  input  logic                       free,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCMP-1:0]            match
);

  localparam logic [31:0] ALL1 = 32'({CNT_W{1'b1}});

  logic [CNT_W-1:0] nxt;

  assign nxt = CNT_W'(cnt_step(32'(cnt), 32'(cmp[0]), free, ALL1));

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign match[k] = adv && (nxt == cmp[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (adv)  cnt <= nxt;
  end

endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer import tmr_pkg::*; #(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 12,
  parameter int SWR_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_hf,
  input  logic        tick_ext,
  input  logic        tick_slow,
  input  logic        tick_fix,
  output logic        irq
);

  localparam int NCMP  = 3;
  localparam int SWR_W = $clog2(SWR_CYC + 1);

  ctrl_t                     ctrl_q;
  logic [PRE_W-1:0]          pre_q;
  logic [NCMP-1:0]           stat_q;
  logic [NCMP-1:0]           ien_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [SWR_W-1:0]          swr_cnt;
  logic [CNT_W-1:0]          cnt;
  logic [NCMP-1:0]           match;
  logic                      adv;

  reg_addr_e a;
  assign a = reg_addr_e'(bus_addr);

  // Named internal events
  logic            swr_busy, wr_ok, wr_ctrl, swr_start, soft_clr;
  logic [NCMP-1:0] clr_evt;

  assign swr_busy  = (swr_cnt != '0);
  assign wr_ok     = bus_wr && !swr_busy;
  assign wr_ctrl   = wr_ok && (a == A_CTRL);
  assign swr_start = wr_ctrl && bus_wdata[CB_SWR];
  assign soft_clr  = swr_start || swr_busy;
  assign clr_evt   = (wr_ok && a == A_STAT) ? bus_wdata[NCMP-1:0] : '0;

  tmr_tick_gen #(.PRE_W(PRE_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .run(ctrl_q.en),
    .sel(ctrl_q.sel), .fix_en(ctrl_q.fix_en),
    .tick_hf(tick_hf), .tick_ext(tick_ext), .tick_slow(tick_slow), .tick_fix(tick_fix),
    .pre(pre_q), .adv(adv)
  );

  tmr_count_core #(.CNT_W(CNT_W), .NCMP(NCMP)) i_core (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .adv(adv), .free(ctrl_q.free),
    .cmp(cmp_q), .cnt(cnt), .match(match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (swr_start) begin
      ctrl_q    <= ctrl_from_word(bus_wdata);
      ctrl_q.en <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_from_word(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      swr_cnt <= '0;
    else if (swr_start)              swr_cnt <= SWR_W'(SWR_CYC);
    else if (swr_busy)               swr_cnt <= swr_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else if (soft_clr) begin
      pre_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ok && a == A_PRE) pre_q <= bus_wdata[PRE_W-1:0];
      if (wr_ok && a == A_IEN) ien_q <= bus_wdata[NCMP-1:0];
      stat_q <= (stat_q & ~clr_evt) | match;
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmpreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q[k] <= '0;
      else if (soft_clr) cmp_q[k] <= '0;
      else if (wr_ok && bus_addr == 3'(int'(A_CMP1) + k))
        cmp_q[k] <= bus_wdata[CNT_W-1:0];
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    case (a)
      A_CTRL:  bus_rdata = ctrl_to_word(ctrl_q, swr_busy);
      A_PRE:   bus_rdata = 32'(pre_q);
      A_STAT:  bus_rdata = 32'(stat_q);
      A_IEN:   bus_rdata = 32'(ien_q);
      A_CMP1:  bus_rdata = 32'(cmp_q[0]);
      A_CMP2:  bus_rdata = 32'(cmp_q[1]);
      A_CMP3:  bus_rdata = 32'(cmp_q[2]);
      default: bus_rdata = 32'(cnt);
    endcase
  end

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int CNT_W   = 32,
  parameter int NCMP    = 3,
  parameter int SWR_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NCMP-1:0]  stat_q,
  input logic [NCMP-1:0]  match,
  input logic [NCMP-1:0]  clr_evt,
  input logic             swr_busy,
  input logic             soft_clr,
  input logic             run,
  input logic             free,
  input logic             adv,
  input logic [CNT_W-1:0] cnt
);

  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bcnt <= '0;
    else if (!swr_busy) bcnt <= '0;
    else                bcnt <= bcnt + 32'd1;
  end

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|match) && !soft_clr) |=> ((stat_q & $past(match)) == $past(match)));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(clr_evt & ~match)) && !soft_clr) |=> ((stat_q & $past(clr_evt & ~match)) == '0));

  // R11
  swr_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> (bcnt < SWR_CYC));

  // R11
  swr_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swr_busy) |-> ($past(bcnt) == SWR_CYC - 1));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !soft_clr) |=> $stable(cnt));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && free && !soft_clr && cnt == '1) |=> (cnt == '0));

endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W), .NCMP(NCMP), .SWR_CYC(SWR_CYC)) i_tmr_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .stat_q(stat_q), .match(match),
  .clr_evt(clr_evt), .swr_busy(swr_busy), .soft_clr(soft_clr),
  .run(ctrl_q.en), .free(ctrl_q.free), .adv(adv), .cnt(cnt)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;

  localparam int CW = 12;
  localparam logic [3:0] T_HF = 4'b0001, T_EXT = 4'b0010, T_SLOW = 4'b0100, T_FIX = 4'b1000;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0] tk = 0;
  logic irq;

  always #2 clk = ~clk;

  cmp_timer #(.CNT_W(CW), .PRE_W(4), .SWR_CYC(4)) i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_hf(tk[0]), .tick_ext(tk[1]), .tick_slow(tk[2]), .tick_fix(tk[3]), .irq(irq)
  );

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic mon_rd = 0;
  bit done = 0;

  // Monitor: pops expected items and compares with the design's result
  always @(negedge clk) begin
    if (mon_rd && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] ctl(bit en, int sel, bit free, bit fix);
    return 32'(en) | (32'(sel) << 1) | (32'(free) << 4) | (32'(fix) << 5);
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic write_tick(input logic [2:0] a, input logic [31:0] d, input logic [3:0] m);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d; tk = m;
    @(posedge clk); #1;
    bus_wr = 0; tk = 0;
  endtask

  task automatic pulses(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tk = m;
    end
    @(posedge clk); #1; tk = 0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    bus_addr = a; mon_rd = 1;
    @(negedge clk); #1;
    mon_rd = 0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    mon_rd = 1;
    @(negedge clk); #1;
    mon_rd = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_rd(3'd0, 32'h0, "R1 ctrl");
    expect_rd(3'd1, 32'h0, "R1 pre");
    expect_rd(3'd2, 32'h0, "R1 stat");
    expect_rd(3'd7, 32'h0, "R1 count");
    expect_rd(3'd5, 32'h0, "R1 cmp2");
    expect_irq(1'b0, "R1 irq");

    // R2/R3 ext source, no division
    bus_write(3'd0, ctl(1, 3, 1, 0));
    pulses(T_EXT, 5);
    expect_rd(3'd7, 32'd5, "R2 ext count");
    pulses(T_HF, 3);
    expect_rd(3'd7, 32'd5, "R2 unselected source ignored");
    // R3 divide by 3
    bus_write(3'd1, 32'd2);
    pulses(T_EXT, 9);
    expect_rd(3'd7, 32'd8, "R3 prescale 2");
    bus_write(3'd1, 32'd0);

    // R4 stop
    bus_write(3'd0, 32'h0);
    pulses(T_EXT, 4);
    expect_rd(3'd7, 32'd8, "R4 stopped count");
    expect_rd(3'd0, 32'h0, "R4 ctrl cleared");

    // R2 other sources
    bus_write(3'd0, ctl(1, 0, 1, 0));
    pulses(4'hF, 4);
    expect_rd(3'd7, 32'd8, "R2 no source");
    bus_write(3'd0, ctl(1, 5, 1, 0));
    pulses(T_FIX, 3);
    expect_rd(3'd7, 32'd8, "R2 fixed source disabled");
    bus_write(3'd0, ctl(1, 5, 1, 1));
    pulses(T_FIX, 3);
    expect_rd(3'd7, 32'd11, "R2 fixed source enabled");
    bus_write(3'd0, ctl(1, 4, 1, 0));
    pulses(T_SLOW, 2);
    expect_rd(3'd7, 32'd13, "R2 slow source");
    bus_write(3'd0, ctl(1, 2, 1, 0));
    pulses(T_HF, 2);
    expect_rd(3'd7, 32'd15, "R2 hf source");
    bus_write(3'd0, ctl(1, 1, 1, 0));
    bus_write(3'd0, 32'h0);
    expect_rd(3'd7, 32'd17, "R2 R4 bus clock window");

    // R7/R8/R10 compare flag
    bus_write(3'd0, ctl(1, 3, 1, 0));
    bus_write(3'd5, 32'd20);
    expect_rd(3'd2, 32'h0, "R7 no flag yet");
    pulses(T_EXT, 3);
    expect_rd(3'd7, 32'd20, "R7 count at cmp2");
    expect_rd(3'd2, 32'h2, "R7 cmp2 flag");
    expect_irq(1'b0, "R10 masked");
    bus_write(3'd3, 32'h2);
    expect_irq(1'b1, "R10 enabled flag");
    bus_write(3'd2, 32'h5);
    expect_rd(3'd2, 32'h2, "R8 zero bit kept");
    bus_write(3'd2, 32'h2);
    expect_rd(3'd2, 32'h0, "R8 one bit cleared");
    expect_irq(1'b0, "R10 after clear");

    // R9 match and clear together
    bus_write(3'd6, 32'd21);
    expect_rd(3'd6, 32'd21, "R1 cmp3 readback");
    write_tick(3'd2, 32'h4, T_EXT);
    expect_rd(3'd2, 32'h4, "R9 match wins");
    bus_write(3'd2, 32'h4);

    // R5 restart mode
    bus_write(3'd0, ctl(1, 3, 0, 0));
    bus_write(3'd4, 32'd24);
    pulses(T_EXT, 5);
    expect_rd(3'd7, 32'd1, "R5 restart at cmp1");
    expect_rd(3'd2, 32'h1, "R5 R7 cmp1 flag");
    bus_write(3'd2, 32'h1);
    bus_write(3'd0, ctl(1, 3, 1, 0));
    bus_write(3'd4, 32'd3);
    pulses(T_EXT, 4);
    expect_rd(3'd7, 32'd5, "R5 free-run past cmp1");

    // R11/R12 software reset
    bus_write(3'd1, 32'd1);
    bus_write(3'd3, 32'd1);
    bus_write(3'd0, 32'h8000 | ctl(1, 3, 1, 1));
    expect_rd(3'd0, 32'h8000 | ctl(0, 3, 1, 1), "R11 busy cycle 2");
    expect_rd(3'd0, 32'h8000 | ctl(0, 3, 1, 1), "R11 busy cycle 3");
    expect_rd(3'd0, 32'h8000 | ctl(0, 3, 1, 1), "R11 busy cycle 4");
    expect_rd(3'd0, ctl(0, 3, 1, 1), "R11 R12 done, bits kept");
    expect_rd(3'd1, 32'h0, "R12 pre cleared");
    expect_rd(3'd3, 32'h0, "R12 ien cleared");
    expect_rd(3'd2, 32'h0, "R12 stat cleared");
    expect_rd(3'd4, 32'h0, "R12 cmp1 cleared");
    expect_rd(3'd6, 32'h0, "R12 cmp3 cleared");
    expect_rd(3'd7, 32'h0, "R12 count cleared");

    // R6 wrap
    bus_write(3'd0, ctl(1, 3, 1, 0));
    bus_write(3'd6, 32'hFFF);
    pulses(T_EXT, 4095);
    expect_rd(3'd7, 32'hFFF, "R6 all ones");
    expect_rd(3'd2, 32'h4, "R6 R7 flag at all ones");
    pulses(T_EXT, 1);
    expect_rd(3'd7, 32'h0, "R6 wrapped to zero");
    expect_rd(3'd2, 32'h7, "R6 R7 flags at zero");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule